// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block chooses which pending event is served next and gives the winner's vector to one of two consumers: the main CPU or a coprocessor. It handles two kinds of source. Peripheral requests are maskable, and each one has a programmable level from 1 to 7 and a routing bit. Exceptions are non-maskable except for the high-priority external request, and they win on a fixed ladder. The block remembers the level the CPU is currently serving, so only requests above that level get through. This lets interrupts nest to any depth on the CPU. The coprocessor nests at most one level deep.

Software writes a level and a route for one request at a time through a small write port. The CPU acknowledges when it fetches a vector. The vector is `{vec_base, index, 0}`, and it is registered, so it is valid in the cycle after the acknowledge. When a handler returns, a pulse from the CPU brings the previous level back. If an acknowledge arrives and nothing is pending, the vector for the spurious index is delivered instead.

Top module: `irq_arbiter`

## Requirements
- R1: After reset every request level is 0 and every route is CPU, `cpu_level` is 0, `cop_depth` is 0, and both vector-valid outputs are low.
- R2: A request whose level is 0 never raises `cpu_irq` or `cop_irq`, whether or not its input is active.
- R3: Among the pending maskable requests routed to the CPU, the one with the highest level wins. When levels tie, the request with the higher index wins.
- R4: A CPU-routed request is eligible only when its level is strictly above `cpu_level`. When the CPU acknowledges a maskable winner, `cpu_level` takes that winner's level on the next cycle. A `cpu_ret` pulse loads `cpu_ret_level`. An acknowledge that takes a maskable winner wins over a `cpu_ret` in the same cycle.
- R5: `irq_mask`=1 blocks every CPU-routed maskable request. `hp_mask`=1 blocks `hp_req`.
- R6: The exception order, highest first, is: `rst_src[2]`, `rst_src[1]`, `rst_src[0]`, `hp_req`, `trap_req`, `swi_req`, `sys_req`, `av_req[2]`, `av_req[1]`, `av_req[0]`. Their indexes are N+10 down to N+1 (N = number of requests), and any exception beats every maskable request.
- R7: Maskable request i has index i. The vector is `vec_base*2^(IDX_W+1) + index*2`. It is registered on an acknowledge, and its valid flag is high for exactly the one cycle after that acknowledge.
- R8: An acknowledge while no eligible source is pending delivers index N, the spurious index. It does not change `cpu_level` or `cop_depth`.
- R9: A request routed to the coprocessor (`cfg_cop`=1) never raises `cpu_irq`. It raises `cop_irq` whatever the state of `irq_mask`, `hp_mask` and `cpu_level`. Its winner is picked by highest level, and a tie goes to the higher index.
- R10: `cop_depth` never exceeds 2. With depth 0 any level above 0 is eligible. With depth 1 a request must be above the running thread's level. With depth 2 nothing is eligible. `cop_ack` with a winner adds one to the depth, and `cop_done` removes one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write enable for the per-request configuration |
| cfg_sel | input | 4 | Request being configured |
| cfg_level | input | 3 | Level to write (0 disables the request) |
| cfg_cop | input | 1 | Route to write: 1 = coprocessor, 0 = CPU |
| vec_base | input | 8 | Upper bits of every vector |
| irq_req | input | 16 | Maskable peripheral requests |
| rst_src | input | 3 | Reset sources |
| hp_req | input | 1 | High-priority external request |
| trap_req | input | 1 | Unimplemented-opcode trap |
| swi_req | input | 1 | Software interrupt or debug request |
| sys_req | input | 1 | System-call interrupt |
| av_req | input | 3 | Access-violation interrupts |
| irq_mask | input | 1 | Global mask for CPU-routed maskable requests |
| hp_mask | input | 1 | Mask for the high-priority external request |
| cpu_ack | input | 1 | CPU vector fetch |
| cpu_ret | input | 1 | Return-from-interrupt pulse |
| cpu_ret_level | input | 3 | Level restored by `cpu_ret` |
| cop_ack | input | 1 | Coprocessor vector fetch |
| cop_done | input | 1 | Coprocessor thread finished |
| cpu_irq | output | 1 | A source is pending for the CPU |
| cpu_vec | output | 14 | CPU vector |
| cpu_vec_vld | output | 1 | CPU vector valid, one cycle after `cpu_ack` |
| cpu_level | output | 3 | Level the CPU is currently serving |
| cop_irq | output | 1 | A request is pending for the coprocessor |
| cop_vec | output | 14 | Coprocessor vector |
| cop_vec_vld | output | 1 | Coprocessor vector valid, one cycle after `cop_ack` |
| cop_depth | output | 2 | Coprocessor nesting depth |

## Verification
On every cycle, the assertions check four things. The vector-valid flag matches the previous cycle's acknowledge. An empty acknowledge yields the spurious index. The chosen CPU request sits strictly above the current level. The coprocessor depth stays at 2 or below. Other behaviour needs the bench's scenarios to show it: the tie rule that favours the higher index, the order of the exception ladder, a level-0 request staying silent, and routing that keeps coprocessor requests clear of the CPU masks. The bench's reference model checks all of these every clock, and directed checks compare them against literal vectors.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // exception bits: av0..2, sys, swi, trap, hp, rst0..2
  localparam int EXC_CNT = 10;

  // vector word: base above index, index shifted left by one
  function automatic int vec_word(input int base, input int idx, input int idx_w);
    return (base << (idx_w + 1)) + (idx << 1);
  endfunction

  // index of exception bit pos; n_req itself is the spurious index
  function automatic int exc_index(input int n_req, input int pos);
    return n_req + 1 + pos;
  endfunction
endpackage

// File: rtl/irq_cfg_table.sv
module irq_cfg_table #(
  parameter int N_REQ = 16,
  parameter int LVL_W = 3,
  localparam int SEL_W = $clog2(N_REQ)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [SEL_W-1:0]       sel,
  input  logic [LVL_W-1:0]       lvl_in,
  input  logic                   cop_in,
  output logic [N_REQ*LVL_W-1:0] lvl_flat,
  output logic [N_REQ-1:0]       route
);
  for (genvar g = 0; g < N_REQ; g++) begin : g_ent
    logic [LVL_W-1:0] l_q;
    logic             r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        l_q <= '0;
        r_q <= 1'b0;
      end else if (we && sel == SEL_W'(g)) begin
        l_q <= lvl_in;
        r_q <= cop_in;
      end
    end
    assign lvl_flat[g*LVL_W +: LVL_W] = l_q;
    assign route[g] = r_q;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_REQ = 16,
  parameter int LVL_W = 3,
  localparam int SEL_W = $clog2(N_REQ)
) (
  input  logic [N_REQ-1:0]       req,
  input  logic [N_REQ*LVL_W-1:0] lvl_flat,
  input  logic [N_REQ-1:0]       route,
  input  logic                   want_cop,
  input  logic                   enable,
  input  logic [LVL_W-1:0]       thresh,
  output logic                   found,
  output logic [SEL_W-1:0]       idx,
  output logic [LVL_W-1:0]       lvl
);
  // ascending scan with >= keeps the higher index on equal levels
  always_comb begin
    found = 1'b0;
    idx   = '0;
    lvl   = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (enable && req[i] && route[i] == want_cop &&
          lvl_flat[i*LVL_W +: LVL_W] > thresh &&
          lvl_flat[i*LVL_W +: LVL_W] >= lvl) begin
        found = 1'b1;
        idx   = SEL_W'(i);
        lvl   = lvl_flat[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_push,
  input  logic [LVL_W-1:0] cpu_push_lvl,
  input  logic             cpu_ret,
  input  logic [LVL_W-1:0] cpu_ret_lvl,
  input  logic             cop_push,
  input  logic [LVL_W-1:0] cop_push_lvl,
  input  logic             cop_pop,
  output logic [LVL_W-1:0] cpu_level,
  output logic [LVL_W-1:0] cop_level,
  output logic [1:0]       cop_depth
);
  logic [LVL_W-1:0] cop_outer, cop_inner;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_level <= '0;
    end else if (cpu_push) begin
      cpu_level <= cpu_push_lvl;
    end else if (cpu_ret) begin
      cpu_level <= cpu_ret_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cop_depth <= 2'd0;
      cop_outer <= '0;
      cop_inner <= '0;
    end else if (cop_push) begin
      if (cop_depth == 2'd0) cop_outer <= cop_push_lvl;
      else                   cop_inner <= cop_push_lvl;
      cop_depth <= cop_depth + 2'd1;
    end else if (cop_pop) begin
      cop_depth <= cop_depth - 2'd1;
    end
  end

  assign cop_level = (cop_depth == 2'd2) ? cop_inner :
                     (cop_depth == 2'd1) ? cop_outer : '0;

  AST_CPU_LEVEL_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_push |=> cpu_level == $past(cpu_push_lvl)); // R4
  AST_CPU_LEVEL_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ret && !cpu_push) |=> cpu_level == $past(cpu_ret_lvl)); // R4
  AST_COP_DEPTH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    cop_depth <= 2'd2); // R10
  AST_COP_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_depth == 2'd2) |-> !cop_push); // R10
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_REQ  = 16,
  parameter int LVL_W  = 3,
  parameter int BASE_W = 8,
  localparam int SEL_W = $clog2(N_REQ),
  localparam int IDX_W = $clog2(N_REQ + irq_pkg::EXC_CNT + 1),
  localparam int VEC_W = BASE_W + IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [LVL_W-1:0]  cfg_level,
  input  logic              cfg_cop,
  input  logic [BASE_W-1:0] vec_base,
  input  logic [N_REQ-1:0]  irq_req,
  input  logic [2:0]        rst_src,
  input  logic              hp_req,
  input  logic              trap_req,
  input  logic              swi_req,
  input  logic              sys_req,
  input  logic [2:0]        av_req,
  input  logic              irq_mask,
  input  logic              hp_mask,
  input  logic              cpu_ack,
  input  logic              cpu_ret,
  input  logic [LVL_W-1:0]  cpu_ret_level,
  input  logic              cop_ack,
  input  logic              cop_done,
  output logic              cpu_irq,
  output logic [VEC_W-1:0]  cpu_vec,
  output logic              cpu_vec_vld,
  output logic [LVL_W-1:0]  cpu_level,
  output logic              cop_irq,
  output logic [VEC_W-1:0]  cop_vec,
  output logic              cop_vec_vld,
  output logic [1:0]        cop_depth
);
  import irq_pkg::*;

  localparam int POS_W = $clog2(EXC_CNT);
  localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(N_REQ);

  logic [N_REQ*LVL_W-1:0] lvl_flat;
  logic [N_REQ-1:0]       route;
  logic                   cpu_found, cop_found;
  logic [SEL_W-1:0]       cpu_pick_idx, cop_pick_idx;
  logic [LVL_W-1:0]       cpu_pick_lvl, cop_pick_lvl, cop_level;
  logic [EXC_CNT-1:0]     exc_bits;
  logic                   exc_hit;
  logic [POS_W-1:0]       exc_pos;
  logic [IDX_W-1:0]       cpu_win_idx, cpu_sel_idx, cop_sel_idx;
  logic                   cpu_take_mask, cop_take, cop_pop;

  irq_cfg_table #(.N_REQ(N_REQ), .LVL_W(LVL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .lvl_in(cfg_level),
    .cop_in(cfg_cop), .lvl_flat(lvl_flat), .route(route));

  irq_pick #(.N_REQ(N_REQ), .LVL_W(LVL_W)) u_cpu_pick (
    .req(irq_req), .lvl_flat(lvl_flat), .route(route), .want_cop(1'b0),
    .enable(!irq_mask), .thresh(cpu_level),
    .found(cpu_found), .idx(cpu_pick_idx), .lvl(cpu_pick_lvl));

  irq_pick #(.N_REQ(N_REQ), .LVL_W(LVL_W)) u_cop_pick (
    .req(irq_req), .lvl_flat(lvl_flat), .route(route), .want_cop(1'b1),
    .enable(cop_depth != 2'd2), .thresh(cop_level),
    .found(cop_found), .idx(cop_pick_idx), .lvl(cop_pick_lvl));

  // exception ladder: the higher bit wins
  assign exc_bits = {rst_src, hp_req & ~hp_mask, trap_req, swi_req, sys_req, av_req};
  assign exc_hit  = |exc_bits;

  always_comb begin
    exc_pos = '0;
    for (int j = 0; j < EXC_CNT; j++) begin
      if (exc_bits[j]) exc_pos = POS_W'(j);
    end
  end

  assign cpu_win_idx = exc_hit ? IDX_W'(exc_index(N_REQ, int'(exc_pos)))
                               : IDX_W'(cpu_pick_idx);
  assign cpu_irq     = exc_hit | cpu_found;
  assign cop_irq     = cop_found;
  assign cpu_sel_idx = cpu_irq ? cpu_win_idx : SPUR_IDX;
  assign cop_sel_idx = cop_found ? IDX_W'(cop_pick_idx) : SPUR_IDX;

  // named events for the nesting tracker
  assign cpu_take_mask = cpu_ack & ~exc_hit & cpu_found;
  assign cop_take      = cop_ack & cop_found;
  assign cop_pop       = cop_done & (cop_depth != 2'd0) & ~cop_take;

  irq_nest #(.LVL_W(LVL_W)) u_nest (
    .clk(clk), .rst_n(rst_n),
    .cpu_push(cpu_take_mask), .cpu_push_lvl(cpu_pick_lvl),
    .cpu_ret(cpu_ret), .cpu_ret_lvl(cpu_ret_level),
    .cop_push(cop_take), .cop_push_lvl(cop_pick_lvl), .cop_pop(cop_pop),
    .cpu_level(cpu_level), .cop_level(cop_level), .cop_depth(cop_depth));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_vec     <= '0;
      cpu_vec_vld <= 1'b0;
      cop_vec     <= '0;
      cop_vec_vld <= 1'b0;
    end else begin
      cpu_vec_vld <= cpu_ack;
      cop_vec_vld <= cop_ack;
      if (cpu_ack) cpu_vec <= VEC_W'(vec_word(int'(vec_base), int'(cpu_sel_idx), IDX_W));
      if (cop_ack) cop_vec <= VEC_W'(vec_word(int'(vec_base), int'(cop_sel_idx), IDX_W));
    end
  end

  AST_VLD_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> cpu_vec_vld); // R7
  AST_VLD_ONLY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ack |=> !cpu_vec_vld); // R7
  AST_SPURIOUS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !cpu_irq) |=> cpu_vec[IDX_W:1] == SPUR_IDX); // R8
  AST_CPU_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_found |-> cpu_pick_lvl > cpu_level); // R4
  AST_COP_ABOVE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    cop_found |-> cop_pick_lvl > cop_level); // R10
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask && !exc_hit) |-> !cpu_irq); // R5
endmodule

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
  localparam int CLK_P = 10;
  localparam int N     = 16;
  localparam int IDXW  = 5;
  localparam int BASE  = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_cop = 0, hp_req = 0, trap_req = 0, swi_req = 0, sys_req = 0;
  logic irq_mask = 0, hp_mask = 0, cpu_ack = 0, cpu_ret = 0, cop_ack = 0, cop_done = 0;
  logic [3:0]  cfg_sel = 0;
  logic [2:0]  cfg_level = 0, rst_src = 0, av_req = 0, cpu_ret_level = 0;
  logic [7:0]  vec_base = 8'(BASE);
  logic [N-1:0] irq_req = 0;
  logic        cpu_irq, cpu_vec_vld, cop_irq, cop_vec_vld;
  logic [13:0] cpu_vec, cop_vec;
  logic [2:0]  cpu_level;
  logic [1:0]  cop_depth;

  always #(CLK_P/2) clk = ~clk;

  irq_arbiter u_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_level(cfg_level),
    .cfg_cop(cfg_cop), .vec_base(vec_base), .irq_req(irq_req), .rst_src(rst_src),
    .hp_req(hp_req), .trap_req(trap_req), .swi_req(swi_req), .sys_req(sys_req),
    .av_req(av_req), .irq_mask(irq_mask), .hp_mask(hp_mask), .cpu_ack(cpu_ack),
    .cpu_ret(cpu_ret), .cpu_ret_level(cpu_ret_level), .cop_ack(cop_ack),
    .cop_done(cop_done), .cpu_irq(cpu_irq), .cpu_vec(cpu_vec), .cpu_vec_vld(cpu_vec_vld),
    .cpu_level(cpu_level), .cop_irq(cop_irq), .cop_vec(cop_vec),
    .cop_vec_vld(cop_vec_vld), .cop_depth(cop_depth));

  int n_chk = 0, n_fail = 0;
  // reference model state
  int m_lvl [N];
  int m_cop [N];
  int m_cpu_lvl = 0, m_cpu_vec = 0, m_cop_vec = 0;
  bit m_cpu_vld = 0, m_cop_vld = 0;
  int cop_stack [$];

  function automatic int vw(input int idx);
    return BASE * (2 ** (IDXW + 1)) + idx * 2;
  endfunction

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  // CPU winner: -1 when none; mw set when a maskable request won
  function automatic int cpu_winner(output bit mw, output int wl);
    int best = -1;
    mw = 0; wl = 0;
    if (rst_src[2]) return N + 10;
    if (rst_src[1]) return N + 9;
    if (rst_src[0]) return N + 8;
    if (hp_req && !hp_mask) return N + 7;
    if (trap_req) return N + 6;
    if (swi_req) return N + 5;
    if (sys_req) return N + 4;
    if (av_req[2]) return N + 3;
    if (av_req[1]) return N + 2;
    if (av_req[0]) return N + 1;
    if (!irq_mask) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (irq_req[i] && m_cop[i] == 0 && m_lvl[i] > m_cpu_lvl && m_lvl[i] > wl) begin
          best = i; wl = m_lvl[i];
        end
      end
    end
    mw = (best >= 0);
    return best;
  endfunction

  function automatic int cop_winner(output int wl);
    int best = -1;
    int thr = (cop_stack.size() == 0) ? 0 : cop_stack[$];
    wl = 0;
    if (cop_stack.size() >= 2) return -1;
    for (int i = N - 1; i >= 0; i--) begin
      if (irq_req[i] && m_cop[i] == 1 && m_lvl[i] > thr && m_lvl[i] > wl) begin
        best = i; wl = m_lvl[i];
      end
    end
    return best;
  endfunction

  // compare mid-cycle, then advance the model across one rising edge
  task automatic step();
    bit mw; int cw, cwl, pw, pwl;
    #(CLK_P/4);
    cw = cpu_winner(mw, cwl);
    pw = cop_winner(pwl);
    check("R3 cpu_irq", int'(cpu_irq), int'(cw >= 0));
    check("R9 cop_irq", int'(cop_irq), int'(pw >= 0));
    check("R7 cpu_vec_vld", int'(cpu_vec_vld), int'(m_cpu_vld));
    check("R7 cpu_vec", int'(cpu_vec), m_cpu_vec);
    check("R4 cpu_level", int'(cpu_level), m_cpu_lvl);
    check("R9 cop_vec_vld", int'(cop_vec_vld), int'(m_cop_vld));
    check("R9 cop_vec", int'(cop_vec), m_cop_vec);
    check("R10 cop_depth", int'(cop_depth), cop_stack.size());
    if (cfg_we) begin
      m_lvl[cfg_sel] = int'(cfg_level);
      m_cop[cfg_sel] = int'(cfg_cop);
    end
    m_cpu_vld = cpu_ack;
    if (cpu_ack) m_cpu_vec = vw(cw >= 0 ? cw : N);
    if (cpu_ack && mw) m_cpu_lvl = cwl;
    else if (cpu_ret) m_cpu_lvl = int'(cpu_ret_level);
    m_cop_vld = cop_ack;
    if (cop_ack) m_cop_vec = vw(pw >= 0 ? pw : N);
    if (cop_ack && pw >= 0) cop_stack.push_back(pwl);
    else if (cop_done && cop_stack.size() > 0) void'(cop_stack.pop_back());
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input int sel, input int lvl, input bit cop);
    cfg_we = 1; cfg_sel = 4'(sel); cfg_level = 3'(lvl); cfg_cop = cop;
    step();
    cfg_we = 0;
  endtask

  task automatic cpu_fetch();
    cpu_ack = 1; step(); cpu_ack = 0;
  endtask

  task automatic cop_fetch();
    cop_ack = 1; step(); cop_ack = 0;
  endtask

  bit finished = 0;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_lvl[i] = 0; m_cop[i] = 0; end
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 reset cpu_level", int'(cpu_level), 0);
    check("R1 reset cop_depth", int'(cop_depth), 0);
    check("R1 reset cpu_vec_vld", int'(cpu_vec_vld), 0);
    check("R1 reset cop_vec_vld", int'(cop_vec_vld), 0);
    irq_req = '1;
    step();
    check("R1 R2 all levels zero", int'(cpu_irq | cop_irq), 0);
    irq_req = '0;

    cfg(3, 2, 0); cfg(5, 2, 0); cfg(12, 6, 0);
    cfg(7, 4, 1); cfg(10, 5, 1); cfg(11, 7, 1);

    // tie at level 2 resolves to the higher index
    irq_req = 16'h0228;
    step();
    check("R3 pending", int'(cpu_irq), 1);
    cpu_fetch();
    check("R3 tie winner", int'(cpu_vec), vw(5));
    check("R7 vld after ack", int'(cpu_vec_vld), 1);
    check("R4 level raised", int'(cpu_level), 2);
    check("R4 same level blocked", int'(cpu_irq), 0);
    step();
    check("R7 vld one cycle", int'(cpu_vec_vld), 0);

    // level 0 disables request 9
    cfg(9, 3, 0);
    check("R2 enabled request", int'(cpu_irq), 1);
    cfg(9, 0, 0);
    check("R2 level zero silent", int'(cpu_irq), 0);

    irq_req = irq_req | 16'h1000;
    step();
    cpu_fetch();
    check("R4 nested winner", int'(cpu_vec), vw(12));
    check("R4 nested level", int'(cpu_level), 6);
    cpu_ret = 1; cpu_ret_level = 3'd2; step(); cpu_ret = 0;
    check("R4 level restored", int'(cpu_level), 2);

    irq_mask = 1; step();
    check("R5 mask blocks", int'(cpu_irq), 0);
    hp_req = 1; hp_mask = 1; step();
    check("R5 hp masked", int'(cpu_irq), 0);
    hp_mask = 0; step();
    cpu_fetch();
    check("R6 hp vector", int'(cpu_vec), vw(N + 7));
    check("R6 exception keeps level", int'(cpu_level), 2);
    hp_req = 0; irq_mask = 0;

    av_req = 3'b001; sys_req = 1; cpu_fetch();
    check("R6 sys over av", int'(cpu_vec), vw(N + 4));
    trap_req = 1; cpu_fetch();
    check("R6 trap over sys", int'(cpu_vec), vw(N + 6));
    rst_src = 3'b010; cpu_fetch();
    check("R6 reset first", int'(cpu_vec), vw(N + 9));
    rst_src = 0; trap_req = 0; sys_req = 0; av_req = 0;

    irq_req = '0; step();
    check("R8 nothing pending", int'(cpu_irq), 0);
    cpu_fetch();
    check("R8 spurious vector", int'(cpu_vec), vw(N));
    check("R8 level kept", int'(cpu_level), 2);

    irq_req = 16'h0080; irq_mask = 1; hp_mask = 1; step();
    check("R9 cop routed", int'(cop_irq), 1);
    check("R9 not to cpu", int'(cpu_irq), 0);
    cop_fetch();
    check("R9 cop vector", int'(cop_vec), vw(7));
    check("R10 depth one", int'(cop_depth), 1);
    irq_req = 16'h0480; step();
    cop_fetch();
    check("R10 preempt vector", int'(cop_vec), vw(10));
    check("R10 depth two", int'(cop_depth), 2);
    irq_req = 16'h0C80; step();
    check("R10 full blocks", int'(cop_irq), 0);
    cop_done = 1; step(); cop_done = 0;
    check("R10 pop depth", int'(cop_depth), 1);
    check("R10 higher allowed", int'(cop_irq), 1);
    cop_done = 1; step(); cop_done = 0;
    irq_req = '0; cop_fetch();
    check("R8 cop spurious", int'(cop_vec), vw(N));
    check("R8 cop depth kept", int'(cop_depth), 0);
    irq_mask = 0; hp_mask = 0;

    // mixed traffic checked by the model every clock
    for (int k = 0; k < 600; k++) begin
      irq_req  = N'($urandom);
      cfg_we   = ($urandom % 8) == 0;
      cfg_sel  = 4'($urandom);
      cfg_level = 3'($urandom);
      cfg_cop  = 1'($urandom);
      irq_mask = ($urandom % 4) == 0;
      hp_mask  = 1'($urandom);
      hp_req   = ($urandom % 8) == 0;
      trap_req = ($urandom % 16) == 0;
      sys_req  = ($urandom % 16) == 0;
      av_req   = (($urandom % 8) == 0) ? 3'($urandom) : 3'd0;
      rst_src  = (($urandom % 32) == 0) ? 3'($urandom) : 3'd0;
      cpu_ack  = ($urandom % 3) == 0;
      cpu_ret  = ($urandom % 5) == 0;
      cpu_ret_level = 3'($urandom);
      cop_ack  = ($urandom % 3) == 0;
      cop_done = ($urandom % 4) == 0;
      step();
    end
    finished = 1;
    summary();
  end
endmodule